// File: doc/BRIEF.md
# Precision time requester clock corrector

This block runs the requester side of one PCIe Precision Time Measurement exchange. A request strobe captures the local time at which the request leaves. That value is also moved later by a programmable transmit latency, so that it stands for the instant the request crosses the port. A response strobe captures the local time of arrival, moved earlier by a programmable receive latency. The same strobe latches the responder's own receive and transmit timestamps, which come with the response.

One cycle after the response is taken, the block forms the link round trip as a signed value. It halves that value with a sign-preserving shift and derives the master time that belongs to the corrected request instant. It also derives the signed offset between that master time and the local request time. When the offset magnitude is within a programmed limit, the new time and offset are pushed out with a one-cycle done strobe. Otherwise a one-cycle sanity strobe fires and nothing is updated. A negative round trip, which appears when the programmed latencies are too large or the two clocks drift over a very short link, gives a small, correct answer and never an offset near 2^63 ns.

A 32-bit register port reads all captured values and writes the two latencies and the limit.

Top module: `ptm_req_time_fix`

## Requirements
- R1: After reset, upd_done, sane_err, upd_time and upd_offset are 0. Both latency registers read 0 and the limit register reads the THR_RST parameter value.
- R2: The register map is: address 0 = transmit latency, 1 = receive latency, 2 = offset limit, all read/write. Addresses 4 to 13 are read-only 64-bit values, low word at the even address. A write to a read-only address changes nothing, and address 3, 14 and 15 read 0.
- R3: On req_sent, the raw local time is kept at addresses 6/7 and local time plus the transmit latency is kept at addresses 4/5 (t1). A request is then outstanding.
- R4: A response is taken when resp_valid is high, a request is outstanding and req_sent is low. The raw local time is kept at 10/11 and local time minus the receive latency at 8/9 (t4). resp_t2 and resp_t3 are latched, and the request is no longer outstanding.
- R5: The round trip is (t4 - t1) - (t3 - t2) as a signed value, and the master time is t2 minus half of it. upd_done is high for exactly one cycle after the second rising edge that follows a taken response.
- R6: A negative round trip gives master time t2 + |round trip|/2 and no huge offset.
- R7: Halving an odd round trip rounds toward minus infinity (for example -61 gives -31).
- R8: upd_time is the master time, upd_offset is the signed 65-bit value master - t1, and addresses 12/13 read upd_time.
- R9: When |upd_offset| would exceed the limit, sane_err pulses for one cycle instead of upd_done. upd_time, upd_offset and addresses 12/13 then keep their previous values. An offset equal to the limit is accepted.
- R10: resp_valid with no outstanding request, or together with req_sent, is ignored. No strobe follows and the t4 registers keep their values. A second response after a taken one is also ignored.
- R11: upd_done and sane_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_time | input | 64 | Free-running local nanosecond count |
| req_sent | input | 1 | Request leaves this cycle |
| resp_valid | input | 1 | Response with responder timestamps arrives this cycle |
| resp_t2 | input | 64 | Responder receive timestamp |
| resp_t3 | input | 64 | Responder transmit timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| upd_done | output | 1 | One-cycle strobe, time update issued |
| sane_err | output | 1 | One-cycle strobe, update refused by the limit |
| upd_time | output | 64 | Master time for the corrected request instant |
| upd_offset | output | 65 | Signed offset master - t1 |

## Verification
The bench uses the default parameters: 64-bit timestamps, 32-bit latency and limit registers, and a 4-bit address. It programs the limit itself, so the exact equality boundary of the sanity check is reachable at small offsets. Because the latency registers are 32 bits wide, latencies of a few hundred nanoseconds drive the round trip negative, with both even and odd values. This brings the sign and rounding behaviour within reach next to an ordinary positive exchange.

// File: rtl/ptm_fix_pkg.sv
package ptm_fix_pkg;
  localparam int TS_W = 64;
  typedef logic [TS_W-1:0]      ts_t;
  typedef logic signed [TS_W:0] sdiff_t;

  function automatic sdiff_t widen(input ts_t v);
    return $signed({1'b0, v});
  endfunction

  // signed round trip from the four stamps
  function automatic sdiff_t rtt_calc(input ts_t t1, input ts_t t2,
                                      input ts_t t3, input ts_t t4);
    return (widen(t4) - widen(t1)) - (widen(t3) - widen(t2));
  endfunction

  // sign-preserving halving
  function automatic sdiff_t halve(input sdiff_t v);
    return v >>> 1;
  endfunction

  function automatic ts_t master_at(input ts_t t2, input sdiff_t half);
    sdiff_t m;
    m = widen(t2) - half;
    return m[TS_W-1:0];
  endfunction

  function automatic sdiff_t offset_of(input ts_t m, input ts_t t1);
    return widen(m) - widen(t1);
  endfunction

  function automatic logic [TS_W:0] magnitude(input sdiff_t v);
    return v[TS_W] ? (TS_W+1)'(-v) : (TS_W+1)'(v);
  endfunction
endpackage

// File: rtl/ptm_stamp_capture.sv
module ptm_stamp_capture
  import ptm_fix_pkg::*;
#(
  parameter int LAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ts_t              local_time,
  input  logic             req_sent,
  input  logic             resp_valid,
  input  ts_t              resp_t2,
  input  ts_t              resp_t3,
  input  logic [LAT_W-1:0] tx_lat,
  input  logic [LAT_W-1:0] rx_lat,
  output ts_t              t1,
  output ts_t              t1_raw,
  output ts_t              t4,
  output ts_t              t4_raw,
  output ts_t              t2_q,
  output ts_t              t3_q,
  output logic             pend,
  output logic             resp_take,
  output logic             calc_go
);
  assign resp_take = resp_valid & pend & ~req_sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1      <= '0;
      t1_raw  <= '0;
      t4      <= '0;
      t4_raw  <= '0;
      t2_q    <= '0;
      t3_q    <= '0;
      pend    <= 1'b0;
      calc_go <= 1'b0;
    end else begin
      calc_go <= resp_take;
      if (req_sent) begin
        t1_raw <= local_time;
        t1     <= local_time + TS_W'(tx_lat);
        pend   <= 1'b1;
      end else if (resp_take) begin
        pend <= 1'b0;
      end
      if (resp_take) begin
        t4_raw <= local_time;
        t4     <= local_time - TS_W'(rx_lat);
        t2_q   <= resp_t2;
        t3_q   <= resp_t3;
      end
    end
  end
endmodule

// File: rtl/ptm_calc.sv
module ptm_calc
  import ptm_fix_pkg::*;
#(
  parameter int THR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             calc_go,
  input  ts_t              t1,
  input  ts_t              t2,
  input  ts_t              t3,
  input  ts_t              t4,
  input  logic [THR_W-1:0] thresh,
  output logic             upd_done,
  output logic             sane_err,
  output ts_t              upd_time,
  output sdiff_t           upd_offset
);
  sdiff_t rtt_w, half_w, off_w;
  ts_t    mast_w;
  logic   too_big;

  always_comb begin
    rtt_w   = rtt_calc(t1, t2, t3, t4);
    half_w  = halve(rtt_w);
    mast_w  = master_at(t2, half_w);
    off_w   = offset_of(mast_w, t1);
    too_big = magnitude(off_w) > (TS_W+1)'(thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_done   <= 1'b0;
      sane_err   <= 1'b0;
      upd_time   <= '0;
      upd_offset <= '0;
    end else begin
      upd_done <= 1'b0;
      sane_err <= 1'b0;
      if (calc_go) begin
        if (too_big) begin
          sane_err <= 1'b1;
        end else begin
          upd_done   <= 1'b1;
          upd_time   <= mast_w;
          upd_offset <= off_w;
        end
      end
    end
  end
endmodule

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_fix_pkg::*;
#(
  parameter int LAT_W   = 32,
  parameter int THR_W   = 32,
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int THR_RST = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  ts_t              t1,
  input  ts_t              t1_raw,
  input  ts_t              t4,
  input  ts_t              t4_raw,
  input  ts_t              res_time,
  output logic [LAT_W-1:0] tx_lat,
  output logic [LAT_W-1:0] rx_lat,
  output logic [THR_W-1:0] thresh,
  output logic [DW-1:0]    reg_rdata
);
  localparam int RO_N    = 5;
  localparam int WPV     = TS_W / DW;
  localparam int RO_BASE = 4;
  localparam int RO_END  = RO_BASE + RO_N * WPV;

  logic [RO_N*TS_W-1:0] ro_flat;
  assign ro_flat = {res_time, t4_raw, t4, t1_raw, t1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lat <= '0;
      rx_lat <= '0;
      thresh <= THR_W'(THR_RST);
    end else if (reg_wr) begin
      case (int'(reg_addr))
        0: tx_lat <= LAT_W'(reg_wdata);
        1: rx_lat <= LAT_W'(reg_wdata);
        2: thresh <= THR_W'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    int sel;
    sel = int'(reg_addr) - RO_BASE;
    reg_rdata = '0;
    case (int'(reg_addr))
      0: reg_rdata = DW'(tx_lat);
      1: reg_rdata = DW'(rx_lat);
      2: reg_rdata = DW'(thresh);
      default: begin
        if (int'(reg_addr) >= RO_BASE && int'(reg_addr) < RO_END)
          reg_rdata = ro_flat[sel*DW +: DW];
      end
    endcase
  end
endmodule

// File: rtl/ptm_req_time_fix.sv
module ptm_req_time_fix
  import ptm_fix_pkg::*;
#(
  parameter int LAT_W   = 32,
  parameter int THR_W   = 32,
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int THR_RST = 1000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TS_W-1:0]     local_time,
  input  logic                req_sent,
  input  logic                resp_valid,
  input  logic [TS_W-1:0]     resp_t2,
  input  logic [TS_W-1:0]     resp_t3,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                upd_done,
  output logic                sane_err,
  output logic [TS_W-1:0]     upd_time,
  output logic signed [TS_W:0] upd_offset
);
  logic [LAT_W-1:0] tx_lat, rx_lat;
  logic [THR_W-1:0] thresh;
  ts_t  t1, t1_raw, t4, t4_raw, t2_q, t3_q;
  logic pend, resp_take, calc_go;

  ptm_stamp_capture #(.LAT_W(LAT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .local_time(local_time),
    .req_sent(req_sent), .resp_valid(resp_valid),
    .resp_t2(resp_t2), .resp_t3(resp_t3),
    .tx_lat(tx_lat), .rx_lat(rx_lat),
    .t1(t1), .t1_raw(t1_raw), .t4(t4), .t4_raw(t4_raw),
    .t2_q(t2_q), .t3_q(t3_q),
    .pend(pend), .resp_take(resp_take), .calc_go(calc_go)
  );

  ptm_calc #(.THR_W(THR_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .calc_go(calc_go),
    .t1(t1), .t2(t2_q), .t3(t3_q), .t4(t4), .thresh(thresh),
    .upd_done(upd_done), .sane_err(sane_err),
    .upd_time(upd_time), .upd_offset(upd_offset)
  );

  ptm_regs #(.LAT_W(LAT_W), .THR_W(THR_W), .AW(AW), .DW(DW), .THR_RST(THR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata),
    .t1(t1), .t1_raw(t1_raw), .t4(t4), .t4_raw(t4_raw), .res_time(upd_time),
    .tx_lat(tx_lat), .rx_lat(rx_lat), .thresh(thresh), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/ptm_fix_chk.sv
module ptm_fix_chk
  import ptm_fix_pkg::*;
#(
  parameter int THR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resp_valid,
  input logic             pend,
  input logic             resp_take,
  input logic             calc_go,
  input logic             upd_done,
  input logic             sane_err,
  input ts_t              upd_time,
  input sdiff_t           upd_offset,
  input logic [THR_W-1:0] thresh
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_done && sane_err));

  // R5
  strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done || sane_err) |-> $past(resp_take, 2));

  // R10
  orphan_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !pend) |=> !calc_go);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_done |-> $stable(upd_time));

  // R9
  limit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> (magnitude(upd_offset) <= (TS_W+1)'(thresh)));
endmodule

bind ptm_req_time_fix ptm_fix_chk #(.THR_W(THR_W)) u_chk (.*);

// File: tb/tb_ptm_req_time_fix.sv
module tb_ptm_req_time_fix;
  localparam int CLK_PER = 10;
  localparam int THR_RST = 1000000;

  logic               clk = 0;
  logic               rst_n = 0;
  logic [63:0]        local_time = 0;
  logic               req_sent = 0, resp_valid = 0;
  logic [63:0]        resp_t2 = 0, resp_t3 = 0;
  logic               reg_wr = 0;
  logic [3:0]         reg_addr = 0;
  logic [31:0]        reg_wdata = 0;
  logic [31:0]        reg_rdata;
  logic               upd_done, sane_err;
  logic [63:0]        upd_time;
  logic signed [64:0] upd_offset;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  ptm_req_time_fix #(.THR_RST(THR_RST)) dut (.*);

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd64(input int a, output logic [63:0] v);
    logic [31:0] lo;
    reg_addr = 4'(a); #1; lo = reg_rdata;
    reg_addr = 4'(a + 1); #1;
    v = {reg_rdata, lo};
  endtask

  // bench model: floor(rtt/2) via division, not shift
  function automatic logic signed [65:0] exp_half(input logic [63:0] t1, t2, t3, t4);
    logic signed [65:0] r;
    r = ($signed({2'b0, t4}) - $signed({2'b0, t1})) - ($signed({2'b0, t3}) - $signed({2'b0, t2}));
    if (r < 0) return (r - 1) / 2;
    return r / 2;
  endfunction

  task automatic do_req(input logic [63:0] lt);
    @(negedge clk);
    local_time = lt; req_sent = 1;
    @(negedge clk);
    req_sent = 0;
  endtask

  // drives a response, returns strobes seen after the second edge
  task automatic do_resp(input logic [63:0] lt, t2, t3, output logic d, output logic e);
    @(negedge clk);
    local_time = lt; resp_t2 = t2; resp_t3 = t3; resp_valid = 1;
    @(negedge clk);
    resp_valid = 0;
    chk("R5 no early strobe", {63'd0, upd_done, sane_err}, 65'd0);
    @(negedge clk);
    d = upd_done; e = sane_err;
    @(negedge clk);
    chk("R5 one-cycle strobe", {63'd0, upd_done, sane_err}, 65'd0);
  endtask

  task automatic exchange(input string tag, input logic [31:0] txl, rxl,
                          input logic [63:0] lt1, lt4, t2, t3);
    logic [63:0] t1, t4, m, v;
    logic signed [64:0] off;
    logic d, e;
    wr(0, txl); wr(1, rxl);
    t1 = lt1 + 64'(txl); t4 = lt4 - 64'(rxl);
    m = 64'($signed({2'b0, t2}) - exp_half(t1, t2, t3, t4));
    off = $signed({1'b0, m}) - $signed({1'b0, t1});
    do_req(lt1);
    rd64(4, v); chk({tag, " R3 t1 adjusted"}, {1'b0, v}, {1'b0, t1});
    rd64(6, v); chk({tag, " R3 t1 raw"}, {1'b0, v}, {1'b0, lt1});
    do_resp(lt4, t2, t3, d, e);
    chk({tag, " R5 done"}, {63'd0, d, e}, 65'd2);
    chk({tag, " R5 master"}, {1'b0, upd_time}, {1'b0, m});
    chk({tag, " R8 offset"}, upd_offset, off);
    rd64(8, v);  chk({tag, " R4 t4 adjusted"}, {1'b0, v}, {1'b0, t4});
    rd64(10, v); chk({tag, " R4 t4 raw"}, {1'b0, v}, {1'b0, lt4});
    rd64(12, v); chk({tag, " R8 result reg"}, {1'b0, v}, {1'b0, m});
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 strobes", {63'd0, upd_done, sane_err}, 65'd0);
    chk("R1 time", {1'b0, upd_time}, 65'd0);
    chk("R1 offset", upd_offset, 65'd0);
    reg_addr = 0; #1; chk("R1 tx lat", 65'(reg_rdata), 65'd0);
    reg_addr = 1; #1; chk("R1 rx lat", 65'(reg_rdata), 65'd0);
    reg_addr = 2; #1; chk("R1 limit", 65'(reg_rdata), 65'(THR_RST));
    rd64(12, v); chk("R1 result reg", {1'b0, v}, 65'd0);
  endtask

  task automatic t_regs;
    wr(0, 32'h1234); wr(1, 32'h55); wr(2, 32'd10000);
    reg_addr = 0; #1; chk("R2 tx rw", 65'(reg_rdata), 65'h1234);
    reg_addr = 1; #1; chk("R2 rx rw", 65'(reg_rdata), 65'h55);
    reg_addr = 2; #1; chk("R2 limit rw", 65'(reg_rdata), 65'd10000);
    wr(5, 32'hdead); wr(12, 32'hbeef);
    reg_addr = 5;  #1; chk("R2 ro write ignored", 65'(reg_rdata), 65'd0);
    reg_addr = 12; #1; chk("R2 ro write ignored res", 65'(reg_rdata), 65'd0);
    reg_addr = 3;  #1; chk("R2 hole reads 0", 65'(reg_rdata), 65'd0);
    reg_addr = 14; #1; chk("R2 addr14 reads 0", 65'(reg_rdata), 65'd0);
    reg_addr = 15; #1; chk("R2 addr15 reads 0", 65'(reg_rdata), 65'd0);
  endtask

  task automatic t_sanity;
    logic d, e; logic [63:0] v;
    // offset 400: limit 400 accepted, 399 refused
    wr(2, 32'd400);
    exchange("R9 equal", 0, 0, 64'd2000, 64'd2300, 64'd2500, 64'd2600);
    wr(2, 32'd399);
    do_req(64'd3000);
    do_resp(64'd3300, 64'd3500, 64'd3600, d, e);
    chk("R9 refused strobe", {63'd0, d, e}, 65'd1);
    chk("R9 time kept", {1'b0, upd_time}, 65'd2400);
    chk("R9 offset kept", upd_offset, 65'd400);
    rd64(12, v); chk("R9 result reg kept", {1'b0, v}, 65'd2400);
    wr(2, 32'd10000);
  endtask

  task automatic t_orphan;
    logic d, e; logic [63:0] v;
    // no request outstanding after last exchange
    do_resp(64'd9000, 64'd1, 64'd2, d, e);
    chk("R10 orphan no strobe", {63'd0, d, e}, 65'd0);
    rd64(10, v); chk("R10 t4 raw kept", {1'b0, v}, 65'd3300);
    // response together with request
    @(negedge clk);
    local_time = 64'd9500; req_sent = 1; resp_valid = 1;
    @(negedge clk);
    req_sent = 0; resp_valid = 0;
    @(negedge clk);
    chk("R10 same-cycle no strobe", {63'd0, upd_done, sane_err}, 65'd0);
    rd64(10, v); chk("R10 same-cycle t4 kept", {1'b0, v}, 65'd3300);
    // now outstanding: take one, then a second is ignored
    do_resp(64'd9600, 64'd9700, 64'd9700, d, e);
    chk("R10 pending taken", {63'd0, d, e}, 65'd2);
    do_resp(64'd9900, 64'd1, 64'd2, d, e);
    chk("R10 second response ignored", {63'd0, d, e}, 65'd0);
    rd64(10, v); chk("R10 t4 after second", {1'b0, v}, 65'd9600);
  endtask

  initial begin
    #(CLK_PER * 3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    // positive round trip 200, master 2400
    exchange("R5 positive", 0, 0, 64'd2000, 64'd2300, 64'd2500, 64'd2600);
    // R6 negative even round trip -60, master 5030
    exchange("R6 negative", 100, 100, 64'd1000, 64'd1150, 64'd5000, 64'd5010);
    // R7 negative odd -61, master 5031
    exchange("R7 odd", 100, 100, 64'd1000, 64'd1150, 64'd5000, 64'd5011);
    chk("R7 master value", {1'b0, upd_time}, 65'd5031);
    t_sanity();
    t_orphan();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule